// File: doc/BRIEF.md
# Two-Channel Serial Host Register Front End

This block is the byte-wide host side of a two-channel serial controller's register set. The host sees four byte locations per controller. One address bit picks the control port or the data port, and another address bit picks channel A or channel B. Behind each channel's control port sit fifteen write registers and a small set of read registers. A per-channel pointer reaches them in two steps. A control write while the pointer is zero loads the pointer. The next control access (a write that stores a byte, or a read that returns one) sends the pointer back to zero.

Register 9's top two bits form a reset command that restores the defaults of either channel or both. The block also turns the stored configuration into the line format (character length, parity, stop bits) and a total clock divisor for the serial engines. The serial bit rate is (input frequency / 2) divided by that divisor. The data port belongs to the shifters and is passed over here. The whole write register file is exposed so that neighbouring logic can read its configuration.

Top module: `sio_host_regs`

## Requirements
- R1: After the synchronous reset, the pointer of both channels is 0 and the write registers hold these values: register 4 = 0x04, register 9 = 0xC0, register 11 = 0x08, register 14 = 0x30, register 15 = 0xF8, and all others 0x00. The format outputs then show 5-bit characters, no parity, one stop bit and a divisor of 2.
- R2: A control write while the pointer is 0 loads the pointer from data bits [2:0]. When bits [5:3] equal 001, 8 is added to the loaded value.
- R3: A control write while the pointer is nonzero stores the byte into the addressed write register and returns the pointer to 0. The one exception is the reset command in R6.
- R4: A control read returns the read register the pointer selects: register 0 = 0x44, register 1 = 0x07, registers 12 and 13 mirror write registers 12 and 13, and every other register = 0x00. The read also returns the pointer to 0.
- R5: A control write at pointer 0 with a command field other than 001 only loads the pointer from bits [2:0]. No register changes.
- R6: A write to register 9 whose bits [7:6] are nonzero is a reset command and stores nothing. The value 01 resets channel B (channel address bit 0), 10 resets channel A (channel address bit 1), and 11 resets both. A reset channel returns to its R1 state.
- R7: A reset command does not move the pointer of the channel that issued it. That pointer stays at 9 unless the same command also resets that channel.
- R8: Data-port accesses (address bit 0 = 1) change no pointer and no register, and a data read returns 0x00.
- R9: The divisor output equals ({register 13, register 12} + 2) multiplied by 1, 16, 32 or 64 when register 4 bits [7:6] are 00, 01, 10 or 11.
- R10: The character length comes from register 5 bits [6:5]: 00 gives 5 bits, 01 gives 7, 10 gives 6 and 11 gives 8.
- R11: Parity is enabled by register 4 bit 0 and is even when bit 1 is set. Two stop bits are selected only when bits [3:2] equal 11.
- R12: An access to one channel leaves the other channel's pointer and registers unchanged, unless it carries a reset command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high, both channels |
| bus_wr | input | 1 | Single-cycle write strobe; takes precedence over bus_rd |
| bus_rd | input | 1 | Single-cycle read strobe, ignored while bus_wr is high |
| bus_addr | input | ADDR_W | Bit 0 selects data (1) or control (0); bit 1 selects channel A (1) or B (0) |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, valid during the read cycle |
| cfg_regs | output | 2×15×8 | Write registers 1 to 15 of each channel, index 0 = channel B |
| char_bits | output | 2×4 | Character length per channel |
| par_en | output | 2 | Parity enable per channel |
| par_even | output | 2 | Even parity per channel |
| stop_two | output | 2 | Two stop bits per channel |
| baud_div | output | 2×DIV_W | Total clock divisor per channel |

## Verification
Two functions can fall on the same write: the reset command and the pointer step of the channel that carries it. The bench loads a pending pointer on channel B, then issues a B reset through channel A. One write therefore clears B's pointer while A's pointer has to stay at 9. The result is judged with a following channel A write, which has to land in register 9, and with a channel B read, which has to return the register 0 value. A reset of both channels issued from one channel covers the case where the hold at 9 and the channel's own reset meet, and the reset has to win.

// File: rtl/sio_regs_pkg.sv
package sio_regs_pkg;

   localparam int unsigned BYTE_W   = 8;
   localparam int unsigned NUM_REGS = 16;
   localparam int unsigned IDX_W    = $clog2(NUM_REGS);
   localparam int unsigned NUM_CH   = 2;

   typedef logic [BYTE_W-1:0] byte_t;
   typedef logic [IDX_W-1:0]  idx_t;

   // register slots whose position other logic depends on
   localparam idx_t IDX_LINE   = idx_t'(4);
   localparam idx_t IDX_CHAR   = idx_t'(5);
   localparam idx_t IDX_MASTER = idx_t'(9);
   localparam idx_t IDX_DIV_LO = idx_t'(12);
   localparam idx_t IDX_DIV_HI = idx_t'(13);

   localparam logic [2:0] CMD_BANK_UP = 3'b001;

   localparam byte_t RD_LINE_STAT = 8'h44;
   localparam byte_t RD_SPEC_STAT = 8'h07;

   typedef enum logic [1:0] {
      PRE_X1  = 2'b00,
      PRE_X16 = 2'b01,
      PRE_X32 = 2'b10,
      PRE_X64 = 2'b11
   } prescale_e;

   function automatic byte_t wr_default(input int unsigned slot);
      case (slot)
         4:       return 8'h04;
         9:       return 8'hC0;
         11:      return 8'h08;
         14:      return 8'h30;
         15:      return 8'hF8;
         default: return 8'h00;
      endcase
   endfunction

endpackage

// File: rtl/sio_cmd_decode.sv
module sio_cmd_decode
   import sio_regs_pkg::*;
(
   input  logic       wr_ctrl,
   input  idx_t       cur_ptr,
   input  byte_t      wdata,
   output logic       ptr_load,
   output idx_t       ptr_next,
   output logic       reg_we,
   output idx_t       reg_idx,
   output logic [1:0] rst_req
);

   always_comb begin
      ptr_load = 1'b0;
      ptr_next = '0;
      reg_we   = 1'b0;
      rst_req  = 2'b00;
      if (wr_ctrl) begin
         if (cur_ptr == '0) begin
            // first step: choose target, optional upper bank
            ptr_load = 1'b1;
            ptr_next = {(wdata[5:3] == CMD_BANK_UP), wdata[2:0]};
         end else if (cur_ptr == IDX_MASTER && wdata[7:6] != 2'b00) begin
            // reset command: pointer left alone
            rst_req = wdata[7:6];
         end else begin
            reg_we   = 1'b1;
            ptr_load = 1'b1;
            ptr_next = '0;
         end
      end
   end

   assign reg_idx = cur_ptr;

endmodule

// File: rtl/sio_fmt_decode.sv
module sio_fmt_decode
   import sio_regs_pkg::*;
#(
   parameter int unsigned BRG_W = 16,
   localparam int unsigned DIV_W = BRG_W + 7
)(
   input  logic [1:0]       pre_code,
   input  logic [1:0]       stop_code,
   input  logic [1:0]       par_code,
   input  logic [1:0]       len_code,
   input  byte_t            div_lo,
   input  byte_t            div_hi,
   output logic [3:0]       char_bits,
   output logic             par_en,
   output logic             par_even,
   output logic             stop_two,
   output logic [DIV_W-1:0] baud_div
);

   logic [BRG_W:0] tc_plus2;
   logic [2:0]     shamt;

   assign tc_plus2 = {1'b0, div_hi, div_lo} + (BRG_W+1)'(2);

   always_comb begin
      case (prescale_e'(pre_code))
         PRE_X1:  shamt = 3'd0;
         PRE_X16: shamt = 3'd4;
         PRE_X32: shamt = 3'd5;
         default: shamt = 3'd6;
      endcase
   end

   assign baud_div = DIV_W'(tc_plus2) << shamt;

   always_comb begin
      case (len_code)
         2'b00:   char_bits = 4'd5;
         2'b01:   char_bits = 4'd7;
         2'b10:   char_bits = 4'd6;
         default: char_bits = 4'd8;
      endcase
   end

   assign par_en   = par_code[0];
   assign par_even = par_code[1];
   assign stop_two = (stop_code == 2'b11);

endmodule

// File: rtl/sio_chan_bank.sv
module sio_chan_bank
   import sio_regs_pkg::*;
#(
   parameter bit MIRROR_BRG = 1'b1
)(
   input  logic                               clk,
   input  logic                               rst,
   input  logic                               chan_rst,
   input  logic                               wr_ctrl,
   input  logic                               rd_ctrl,
   input  byte_t                              wdata,
   output logic [1:0]                         rst_req,
   output byte_t                              rd_val,
   output logic [NUM_REGS-1:1][BYTE_W-1:0]    cfg
);

   idx_t ptr_q;
   logic [NUM_REGS-1:1][BYTE_W-1:0] wreg_q;

   logic ptr_load;
   idx_t ptr_next;
   logic reg_we;
   idx_t reg_idx;

   sio_cmd_decode u_dec (
      .wr_ctrl  (wr_ctrl),
      .cur_ptr  (ptr_q),
      .wdata    (wdata),
      .ptr_load (ptr_load),
      .ptr_next (ptr_next),
      .reg_we   (reg_we),
      .reg_idx  (reg_idx),
      .rst_req  (rst_req)
   );

   always_ff @(posedge clk) begin
      if (rst || chan_rst) begin
         ptr_q <= '0;
         for (int i = 1; i < int'(NUM_REGS); i++) begin
            wreg_q[i] <= wr_default(i);
         end
      end else begin
         for (int i = 1; i < int'(NUM_REGS); i++) begin
            if (reg_we && reg_idx == idx_t'(i)) begin
               wreg_q[i] <= wdata;
            end
         end
         if (ptr_load) begin
            ptr_q <= ptr_next;
         end else if (rd_ctrl) begin
            ptr_q <= '0;
         end
      end
   end

   assign cfg = wreg_q;

   byte_t brg_rd_lo;
   byte_t brg_rd_hi;

   generate
      if (MIRROR_BRG) begin : g_mirror
         assign brg_rd_lo = wreg_q[IDX_DIV_LO];
         assign brg_rd_hi = wreg_q[IDX_DIV_HI];
      end else begin : g_no_mirror
         assign brg_rd_lo = '0;
         assign brg_rd_hi = '0;
      end
   endgenerate

   always_comb begin
      case (ptr_q)
         idx_t'(0):  rd_val = RD_LINE_STAT;
         idx_t'(1):  rd_val = RD_SPEC_STAT;
         IDX_DIV_LO: rd_val = brg_rd_lo;
         IDX_DIV_HI: rd_val = brg_rd_hi;
         default:    rd_val = '0;
      endcase
   end

   // R2: first step loads pointer from the byte
   p_ptr_load_r2: assert property (@(posedge clk) disable iff (rst)
      (wr_ctrl && !chan_rst && ptr_q == '0) |=>
      (ptr_q == {($past(wdata[5:3]) == CMD_BANK_UP), $past(wdata[2:0])}));

   // R3: second step stores and returns pointer home
   p_store_home_r3: assert property (@(posedge clk) disable iff (rst)
      (wr_ctrl && !chan_rst && ptr_q != '0 &&
       !(ptr_q == IDX_MASTER && wdata[7:6] != 2'b00)) |=>
      (ptr_q == '0 && wreg_q[$past(ptr_q)] == $past(wdata)));

   // R4: control read returns pointer home
   p_read_home_r4: assert property (@(posedge clk) disable iff (rst)
      (rd_ctrl && !wr_ctrl && !chan_rst) |=> (ptr_q == '0));

   // R7: reset command leaves issuing pointer at register 9
   p_rst_hold_r7: assert property (@(posedge clk) disable iff (rst)
      (wr_ctrl && !chan_rst && ptr_q == IDX_MASTER && wdata[7:6] != 2'b00) |=>
      (ptr_q == IDX_MASTER));

   // R8 / R12: without a control access nothing moves
   p_quiet_r12: assert property (@(posedge clk) disable iff (rst)
      (!wr_ctrl && !rd_ctrl && !chan_rst) |=> ($stable(ptr_q) && $stable(wreg_q)));

endmodule

// File: rtl/sio_host_regs.sv
module sio_host_regs
   import sio_regs_pkg::*;
#(
   parameter int unsigned ADDR_W       = 2,
   parameter int unsigned CTRL_SEL_BIT = 0,
   parameter int unsigned CHAN_SEL_BIT = 1,
   parameter int unsigned BRG_W        = 16,
   parameter bit          MIRROR_BRG   = 1'b1,
   localparam int unsigned DIV_W       = BRG_W + 7
)(
   input  logic                                     clk,
   input  logic                                     rst,
   input  logic                                     bus_wr,
   input  logic                                     bus_rd,
   input  logic [ADDR_W-1:0]                        bus_addr,
   input  logic [7:0]                               bus_wdata,
   output logic [7:0]                               bus_rdata,
   output logic [1:0][NUM_REGS-1:1][BYTE_W-1:0]     cfg_regs,
   output logic [1:0][3:0]                          char_bits,
   output logic [1:0]                               par_en,
   output logic [1:0]                               par_even,
   output logic [1:0]                               stop_two,
   output logic [1:0][DIV_W-1:0]                    baud_div
);

   // elaboration-time parameter checks
   generate
      if (BRG_W != 2 * BYTE_W) begin : g_bad_brg
         $error("BRG_W must span the two divisor byte registers");
      end
      if (CTRL_SEL_BIT == CHAN_SEL_BIT) begin : g_bad_sel
         $error("control and channel select bits must differ");
      end
      if (CTRL_SEL_BIT >= ADDR_W || CHAN_SEL_BIT >= ADDR_W) begin : g_bad_addr
         $error("select bits must lie inside the address");
      end
   endgenerate

   logic        is_data;
   logic        chan_sel;
   logic [NUM_CH-1:0] wr_ctrl;
   logic [NUM_CH-1:0] rd_ctrl;
   logic [NUM_CH-1:0] chan_rst;
   logic [1:0]  rst_req [NUM_CH];
   byte_t       rd_val  [NUM_CH];

   assign is_data  = bus_addr[CTRL_SEL_BIT];
   assign chan_sel = bus_addr[CHAN_SEL_BIT];

   // reset command bit 0 targets channel B (index 0), bit 1 channel A
   assign chan_rst = rst_req[0] | rst_req[1];

   generate
      for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
         assign wr_ctrl[ch] = bus_wr && !is_data && (chan_sel == ch[0]);
         assign rd_ctrl[ch] = bus_rd && !bus_wr && !is_data && (chan_sel == ch[0]);

         sio_chan_bank #(
            .MIRROR_BRG (MIRROR_BRG)
         ) u_bank (
            .clk      (clk),
            .rst      (rst),
            .chan_rst (chan_rst[ch]),
            .wr_ctrl  (wr_ctrl[ch]),
            .rd_ctrl  (rd_ctrl[ch]),
            .wdata    (bus_wdata),
            .rst_req  (rst_req[ch]),
            .rd_val   (rd_val[ch]),
            .cfg      (cfg_regs[ch])
         );

         sio_fmt_decode #(
            .BRG_W (BRG_W)
         ) u_fmt (
            .pre_code  (cfg_regs[ch][IDX_LINE][7:6]),
            .stop_code (cfg_regs[ch][IDX_LINE][3:2]),
            .par_code  (cfg_regs[ch][IDX_LINE][1:0]),
            .len_code  (cfg_regs[ch][IDX_CHAR][6:5]),
            .div_lo    (cfg_regs[ch][IDX_DIV_LO]),
            .div_hi    (cfg_regs[ch][IDX_DIV_HI]),
            .char_bits (char_bits[ch]),
            .par_en    (par_en[ch]),
            .par_even  (par_even[ch]),
            .stop_two  (stop_two[ch]),
            .baud_div  (baud_div[ch])
         );

         // R10: character length always one of the four legal sizes
         p_len_legal_r10: assert property (@(posedge clk) disable iff (rst)
            (char_bits[ch] >= 4'd5 && char_bits[ch] <= 4'd8));

         // R9: divisor never below the +2 floor
         p_div_floor_r9: assert property (@(posedge clk) disable iff (rst)
            (baud_div[ch] >= DIV_W'(2)));
      end
   endgenerate

   always_comb begin
      bus_rdata = '0;
      for (int ch = 0; ch < int'(NUM_CH); ch++) begin
         if (rd_ctrl[ch]) begin
            bus_rdata = rd_val[ch];
         end
      end
   end

   // R8: data-port reads return zero
   p_data_rd_zero_r8: assert property (@(posedge clk) disable iff (rst)
      (bus_rd && is_data) |-> (bus_rdata == 8'h00));

endmodule

// File: tb/sio_host_regs_bench.sv
`timescale 1ns/1ps
module sio_host_regs_bench;

   localparam int DIV_W = 23;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic bus_wr = 1'b0;
   logic bus_rd = 1'b0;
   logic [1:0] bus_addr = 2'b00;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic [1:0][15:1][7:0] cfg_regs;
   logic [1:0][3:0] char_bits;
   logic [1:0] par_en, par_even, stop_two;
   logic [1:0][DIV_W-1:0] baud_div;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   sio_host_regs u_sio_host_regs (
      .clk       (clk),
      .rst       (rst),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .cfg_regs  (cfg_regs),
      .char_bits (char_bits),
      .par_en    (par_en),
      .par_even  (par_even),
      .stop_two  (stop_two),
      .baud_div  (baud_div)
   );

   function automatic logic [7:0] dflt(input int slot);
      case (slot)
         4: return 8'h04; 9: return 8'hC0; 11: return 8'h08;
         14: return 8'h30; 15: return 8'hF8; default: return 8'h00;
      endcase
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk); rst = 1'b1;
      @(negedge clk); rst = 1'b0;
   endtask

   // ch: 1 = channel A, 0 = channel B
   task automatic ctrl_wr(input bit ch, input logic [7:0] d);
      @(negedge clk);
      bus_addr = {ch, 1'b0}; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic ctrl_rd(input bit ch, output logic [7:0] d);
      @(negedge clk);
      bus_addr = {ch, 1'b0}; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic data_wr(input bit ch, input logic [7:0] d);
      @(negedge clk);
      bus_addr = {ch, 1'b1}; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic data_rd(input bit ch, output logic [7:0] d);
      @(negedge clk);
      bus_addr = {ch, 1'b1}; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic point(input bit ch, input int idx);
      if (idx >= 8) ctrl_wr(ch, {2'b00, 3'b001, 3'(idx)});
      else          ctrl_wr(ch, {5'b00000, 3'(idx)});
   endtask

   task automatic wreg(input bit ch, input int idx, input logic [7:0] v);
      point(ch, idx);
      ctrl_wr(ch, v);
   endtask

   task automatic rreg(input bit ch, input int idx, output logic [7:0] v);
      point(ch, idx);
      ctrl_rd(ch, v);
   endtask

   task automatic t_reset();
      logic [7:0] v;
      do_reset();
      for (int ch = 0; ch < 2; ch++) begin
         for (int r = 1; r < 16; r++) chk("R1 default", cfg_regs[ch][r], dflt(r));
         chk("R1 char", char_bits[ch], 5);
         chk("R1 parity", {par_en[ch], par_even[ch]}, 0);
         chk("R1 stop", stop_two[ch], 0);
         chk("R1 div", baud_div[ch], 2);
         ctrl_rd(bit'(ch), v);
         chk("R1 ptr zero rr0", v, 8'h44);
      end
   endtask

   task automatic t_pointer();
      logic [7:0] v;
      do_reset();
      rreg(1, 1, v);  chk("R4 rr1", v, 8'h07);
      ctrl_rd(1, v);  chk("R4 read returns ptr", v, 8'h44);
      wreg(1, 12, 8'hAB);
      chk("R2 high bank store", cfg_regs[1][12], 8'hAB);
      rreg(1, 12, v); chk("R4 mirror lo", v, 8'hAB);
      wreg(1, 13, 8'h5C);
      rreg(1, 13, v); chk("R4 mirror hi", v, 8'h5C);
      rreg(1, 2, v);  chk("R4 empty rr2", v, 8'h00);
      rreg(1, 15, v); chk("R4 empty rr15", v, 8'h00);
      rreg(1, 4, v);  chk("R4 empty rr4", v, 8'h00);
   endtask

   task automatic t_store();
      logic [7:0] v;
      do_reset();
      wreg(0, 3, 8'h5A);
      chk("R3 store wr3", cfg_regs[0][3], 8'h5A);
      ctrl_rd(0, v); chk("R3 ptr home", v, 8'h44);
      wreg(0, 10, 8'hC3);
      chk("R3 store wr10", cfg_regs[0][10], 8'hC3);
      ctrl_rd(0, v); chk("R3 ptr home high", v, 8'h44);
   endtask

   task automatic t_cmd();
      logic [7:0] v;
      logic [1:0][15:1][7:0] snap;
      do_reset();
      snap = cfg_regs;
      ctrl_wr(0, 8'b00_111_000);
      chk("R5 cmd no change", (cfg_regs === snap), 1);
      ctrl_rd(0, v); chk("R5 ptr zero", v, 8'h44);
      ctrl_wr(0, 8'b00_101_011);
      chk("R5 cmd101 no change", (cfg_regs === snap), 1);
      ctrl_wr(0, 8'h33);
      chk("R5 low bank wr3", cfg_regs[0][3], 8'h33);
      chk("R5 wr11 untouched", cfg_regs[0][11], 8'h08);
   endtask

   task automatic t_indep();
      logic [7:0] v;
      do_reset();
      ctrl_wr(1, 8'h05);
      wreg(0, 5, 8'h60);
      chk("R12 ch0 stored", cfg_regs[0][5], 8'h60);
      chk("R12 ch1 untouched", cfg_regs[1][5], 8'h00);
      ctrl_wr(1, 8'h40);
      chk("R12 ch1 ptr kept", cfg_regs[1][5], 8'h40);
      ctrl_rd(1, v); chk("R12 ch1 ptr home", v, 8'h44);
   endtask

   task automatic t_data();
      logic [7:0] v;
      do_reset();
      ctrl_wr(0, 8'h04);
      data_wr(0, 8'hFF);
      chk("R8 data wr no store", cfg_regs[0][4], 8'h04);
      data_rd(0, v); chk("R8 data rd zero", v, 8'h00);
      ctrl_wr(0, 8'h41);
      chk("R8 ptr survived", cfg_regs[0][4], 8'h41);
   endtask

   task automatic t_format();
      int sh [4] = '{0, 4, 5, 6};
      int lens [4] = '{5, 7, 6, 8};
      do_reset();
      wreg(0, 12, 8'h10);
      wreg(0, 13, 8'h01);
      for (int m = 0; m < 4; m++) begin
         wreg(0, 4, {2'(m), 6'b000000});
         chk("R9 divisor", baud_div[0], 32'd274 << sh[m]);
      end
      wreg(0, 12, 8'hFF);
      wreg(0, 13, 8'hFF);
      chk("R9 divisor max", baud_div[0], 32'h10001 << 6);
      for (int c = 0; c < 4; c++) begin
         wreg(1, 5, {1'b0, 2'(c), 5'b00000});
         chk("R10 length", char_bits[1], lens[c]);
      end
      wreg(1, 4, 8'h01);
      chk("R11 odd", {par_en[1], par_even[1]}, 2'b10);
      wreg(1, 4, 8'h03);
      chk("R11 even", {par_en[1], par_even[1]}, 2'b11);
      wreg(1, 4, 8'h0C);
      chk("R11 two stop", stop_two[1], 1);
      wreg(1, 4, 8'h08);
      chk("R11 one stop", stop_two[1], 0);
      chk("R11 parity off", par_en[1], 0);
   endtask

   task automatic t_reset_cmd();
      logic [7:0] v;
      do_reset();
      wreg(0, 3, 8'h11);
      wreg(1, 3, 8'h22);
      ctrl_wr(0, 8'h02);
      ctrl_wr(1, 8'h09);
      ctrl_wr(1, 8'h40);
      chk("R6 B reset", cfg_regs[0][3], 8'h00);
      chk("R6 A kept", cfg_regs[1][3], 8'h22);
      chk("R6 no store wr9", cfg_regs[1][9], 8'hC0);
      ctrl_rd(0, v); chk("R6 B ptr cleared", v, 8'h44);
      ctrl_wr(1, 8'h15);
      chk("R7 A ptr held at 9", cfg_regs[1][9], 8'h15);
      ctrl_rd(1, v); chk("R7 A ptr home", v, 8'h44);
      wreg(0, 3, 8'h33);
      ctrl_wr(1, 8'h09);
      ctrl_wr(1, 8'h80);
      chk("R6 A reset", cfg_regs[1][3], 8'h00);
      chk("R6 A wr9 dflt", cfg_regs[1][9], 8'hC0);
      chk("R6 B kept", cfg_regs[0][3], 8'h33);
      ctrl_rd(1, v); chk("R6 A ptr cleared", v, 8'h44);
      wreg(1, 3, 8'h44);
      ctrl_wr(0, 8'h09);
      ctrl_wr(0, 8'hC0);
      chk("R6 both B", cfg_regs[0][3], 8'h00);
      chk("R6 both A", cfg_regs[1][3], 8'h00);
      ctrl_rd(0, v); chk("R7 own reset clears ptr", v, 8'h44);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      t_reset();
      t_pointer();
      t_store();
      t_cmd();
      t_indep();
      t_data();
      t_format();
      t_reset_cmd();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule